// File: doc/BRIEF.md
# Dataflow Thread Command Unit

This unit sits next to one processor core and carries out the four thread-management commands that the core's decoder hands over: create a thread, delete the running thread, write a value into a thread frame, and read a value from the running thread's frame. Each command kind has its own small sequencer. A command's latency in cycles equals the number of states in its sequencer. While any sequencer is active, the command port reports busy and the core holds its command.

Only one dataflow thread runs at a time. Its instruction pointer and frame pointer are kept in dedicated registers. Reads never reach the bus: they are answered from a 16-entry local frame store. Writes and create requests become outbound request messages. These messages are posted into a FIFO, and a bus-side interface drains that FIFO in strict order whenever it is ready. As a bus slave, the unit also takes in two kinds of incoming message. A frame-fill message loads one word of the local frame store. A thread-assignment message hands over a ready thread's IP and FP; the thread starts at once if the core is idle, or waits in a one-entry pending register otherwise.

Top module: `dft_cmd_unit`

## Requirements
- R1: After reset, run_valid, out_valid and rsp_valid are 0. With no command in flight, cmd_busy is 0 for a delete or read opcode.
- R2: Opcodes are create=0, delete=1, write=2, read=3. A command is accepted on a clock edge where cmd_valid is 1 and cmd_busy is 0. It completes exactly L cycles later, with L = 3 for create, 2 for delete, 2 for write and 1 for read. cmd_busy is 1 in every cycle between acceptance and completion.
- R3: A read raises rsp_valid for one cycle, in its completion cycle. rsp_data then equals the frame-store entry at the command's offset. A read never produces an outbound message.
- R4: When a write or create completes, one message {kind, fp, off, data} is appended to the outbound FIFO, with kind 0 for a write and 1 for a create. The head of the FIFO is presented on out_* while out_valid is 1. It stays unchanged until out_ready is 1, and messages leave in the order their commands completed.
- R5: With QDEPTH messages queued, cmd_busy is 1 for a write or create opcode and 0 for a delete or read opcode, as long as no command is in flight.
- R6: An incoming message with msg_kind=1 writes msg_data into frame-store entry msg_off at that clock edge.
- R7: An incoming message with msg_kind=0 arriving while no thread runs loads run_ip and run_fp from msg_ip and msg_fp and sets run_valid.
- R8: A thread assignment arriving while a thread runs is held in the pending register. When the next delete completes, the pending thread becomes the running thread. A delete completing in the same cycle as an assignment takes effect first.
- R9: A thread assignment arriving while the pending register is already occupied is ignored.
- R10: A delete that completes with no pending thread clears run_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present from decoder |
| cmd_op | input | 2 | Opcode (0 create, 1 delete, 2 write, 3 read) |
| cmd_fp | input | AW | Target frame pointer (write/create) |
| cmd_off | input | OFFW | Frame offset or create argument |
| cmd_data | input | DW | Write data or new-thread IP |
| cmd_busy | output | 1 | Command cannot be accepted this cycle |
| rsp_valid | output | 1 | Read result valid |
| rsp_data | output | DW | Read result |
| msg_valid | input | 1 | Incoming bus message present |
| msg_kind | input | 1 | 0 thread assignment, 1 frame fill |
| msg_ip | input | AW | Assigned thread IP |
| msg_fp | input | AW | Assigned thread FP |
| msg_off | input | OFFW | Frame-fill offset |
| msg_data | input | DW | Frame-fill data |
| out_valid | output | 1 | Outbound message available |
| out_ready | input | 1 | Bus side takes the head message |
| out_kind | output | 1 | 0 write, 1 create |
| out_fp | output | AW | Message frame pointer |
| out_off | output | OFFW | Message offset field |
| out_data | output | DW | Message data field |
| run_valid | output | 1 | A thread is running |
| run_ip | output | AW | Running thread IP |
| run_fp | output | AW | Running thread FP |

## Verification
The bench builds the unit with its defaults: 32-bit pointers and data, a 16-entry frame store and a 4-deep outbound FIFO. With a 4-deep FIFO, four writes are enough to reach the full stall, and a randomly throttled out_ready refills it often. The pending register is only one entry deep, so assignment messages that run alongside random deletes regularly land on every branch: idle load, pending hold, ignore when occupied, and promotion in the same cycle as a delete.

// File: rtl/dft_pkg.sv
// Shared opcode and message encodings plus per-command sequencer lengths.
// Assumes the decoder presents a 2-bit opcode.
package dft_pkg;
    typedef enum logic [1:0] {
        OP_CREATE = 2'd0,
        OP_DELETE = 2'd1,
        OP_WRITE  = 2'd2,
        OP_READ   = 2'd3
    } dft_op_e;

    localparam logic MSG_ASSIGN = 1'b0;
    localparam logic MSG_FILL   = 1'b1;
    localparam logic OUT_WRITE  = 1'b0;
    localparam logic OUT_CREATE = 1'b1;

    // Number of sequencer states (= latency in cycles) for each opcode.
    function automatic int unsigned op_latency(input int unsigned op);
        case (op)
            0:       return 3;
            1:       return 2;
            2:       return 2;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/dft_op_seq.sv
// One command sequencer: stays active for exactly LAT cycles after start,
// flagging done in its last active cycle. Assumes start only when idle.
module dft_op_seq #(
    parameter int unsigned LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic          act;
    logic [CW-1:0] cnt;

    // Walk through the LAT states, counting down to the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            act <= 1'b1;
            cnt <= CW'(LAT - 1);
        end else if (act) begin
            if (cnt == '0) act <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign busy = act;
    assign done = act && (cnt == '0);
endmodule

// File: rtl/dft_post_fifo.sv
// Posted-message FIFO between the command side and the bus side.
// Assumes DEPTH is a power of two; push is never issued when full.
module dft_post_fifo #(
    parameter int W     = 69,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wptr, rptr;

    // Store pushed entries at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wptr[PW-1:0]] <= push_data;
    end

    // Advance the pointers on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    assign head      = mem[rptr[PW-1:0]];
    assign not_empty = (wptr != rptr);
    assign full      = (wptr[PW] != rptr[PW]) && (wptr[PW-1:0] == rptr[PW-1:0]);
endmodule

// File: rtl/dft_frame_store.sv
// Local frame store of the running thread: register array, one write port
// fed by incoming fill messages, one combinational read port.
module dft_frame_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data
);
    logic [DW-1:0] word [DEPTH];

    // Clear on reset, then accept fill writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) word[i] <= '0;
        end else if (wr_en) begin
            word[wr_idx] <= wr_data;
        end
    end

    assign rd_data = word[rd_idx];
endmodule

// File: rtl/dft_thread_regs.sv
// Running-thread IP/FP registers plus a one-entry pending slot.
// A retire (delete done) is applied before a same-cycle assignment.
module dft_thread_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire,
    input  logic          assign_v,
    input  logic [AW-1:0] assign_ip,
    input  logic [AW-1:0] assign_fp,
    output logic          run_v,
    output logic [AW-1:0] run_ip,
    output logic [AW-1:0] run_fp
);
    logic          pend_v;
    logic [AW-1:0] pend_ip, pend_fp;
    logic          n_run_v, n_pend_v;
    logic [AW-1:0] n_run_ip, n_run_fp, n_pend_ip, n_pend_fp;

    // Next state: retire/promote first, then place any assignment.
    always_comb begin
        n_run_v   = run_v;
        n_run_ip  = run_ip;
        n_run_fp  = run_fp;
        n_pend_v  = pend_v;
        n_pend_ip = pend_ip;
        n_pend_fp = pend_fp;
        if (retire) begin
            n_run_v  = pend_v;
            n_run_ip = pend_ip;
            n_run_fp = pend_fp;
            n_pend_v = 1'b0;
        end
        if (assign_v) begin
            if (!n_run_v) begin
                n_run_v  = 1'b1;
                n_run_ip = assign_ip;
                n_run_fp = assign_fp;
            end else if (!n_pend_v) begin
                n_pend_v  = 1'b1;
                n_pend_ip = assign_ip;
                n_pend_fp = assign_fp;
            end
        end
    end

    // Register the thread state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_v   <= 1'b0;
            run_ip  <= '0;
            run_fp  <= '0;
            pend_v  <= 1'b0;
            pend_ip <= '0;
            pend_fp <= '0;
        end else begin
            run_v   <= n_run_v;
            run_ip  <= n_run_ip;
            run_fp  <= n_run_fp;
            pend_v  <= n_pend_v;
            pend_ip <= n_pend_ip;
            pend_fp <= n_pend_fp;
        end
    end
endmodule

// File: rtl/dft_cmd_unit.sv
// Per-core dataflow thread command unit. Decodes create/delete/write/read
// commands into four sequencers, posts writes and creates into an outbound
// FIFO, serves reads from the local frame store, and accepts incoming
// assignment and frame-fill messages. Assumes one command in flight at once.
module dft_cmd_unit
    import dft_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int FRAME_DEPTH = 16,
    parameter int QDEPTH      = 4,
    parameter int OFFW        = $clog2(FRAME_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [AW-1:0]   cmd_fp,
    input  logic [OFFW-1:0] cmd_off,
    input  logic [DW-1:0]   cmd_data,
    output logic            cmd_busy,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    input  logic            msg_valid,
    input  logic            msg_kind,
    input  logic [AW-1:0]   msg_ip,
    input  logic [AW-1:0]   msg_fp,
    input  logic [OFFW-1:0] msg_off,
    input  logic [DW-1:0]   msg_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic            out_kind,
    output logic [AW-1:0]   out_fp,
    output logic [OFFW-1:0] out_off,
    output logic [DW-1:0]   out_data,
    output logic            run_valid,
    output logic [AW-1:0]   run_ip,
    output logic [AW-1:0]   run_fp
);
    localparam int NOPS = 4;
    localparam int MSGW = 1 + AW + OFFW + DW;

    logic [NOPS-1:0] seq_busy, seq_done, seq_start;
    logic            accept, needs_slot, q_full;
    logic [AW-1:0]   fp_q;
    logic [OFFW-1:0] off_q;
    logic [DW-1:0]   data_q;
    logic [MSGW-1:0] q_head;

    assign needs_slot = (cmd_op == OP_CREATE) || (cmd_op == OP_WRITE);
    assign cmd_busy   = (|seq_busy) || (needs_slot && q_full);
    assign accept     = cmd_valid && !cmd_busy;

    // Capture the operands of an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_q   <= '0;
            off_q  <= '0;
            data_q <= '0;
        end else if (accept) begin
            fp_q   <= cmd_fp;
            off_q  <= cmd_off;
            data_q <= cmd_data;
        end
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_seq
        localparam int unsigned L = op_latency(g);
        assign seq_start[g] = accept && (cmd_op == 2'(g));
        dft_op_seq #(.LAT(L)) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .start (seq_start[g]),
            .busy  (seq_busy[g]),
            .done  (seq_done[g])
        );
    end

    dft_post_fifo #(.W(MSGW), .DEPTH(QDEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (seq_done[OP_CREATE] || seq_done[OP_WRITE]),
        .push_data ({seq_done[OP_CREATE] ? OUT_CREATE : OUT_WRITE, fp_q, off_q, data_q}),
        .pop       (out_valid && out_ready),
        .head      (q_head),
        .not_empty (out_valid),
        .full      (q_full)
    );
    assign {out_kind, out_fp, out_off, out_data} = q_head;

    dft_frame_store #(.DEPTH(FRAME_DEPTH), .DW(DW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (msg_valid && (msg_kind == MSG_FILL)),
        .wr_idx  (msg_off),
        .wr_data (msg_data),
        .rd_idx  (off_q),
        .rd_data (rsp_data)
    );
    assign rsp_valid = seq_done[OP_READ];

    dft_thread_regs #(.AW(AW)) u_thread (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire    (seq_done[OP_DELETE]),
        .assign_v  (msg_valid && (msg_kind == MSG_ASSIGN)),
        .assign_ip (msg_ip),
        .assign_fp (msg_fp),
        .run_v     (run_valid),
        .run_ip    (run_ip),
        .run_fp    (run_fp)
    );
endmodule

// File: rtl/dft_cmd_unit_chk.sv
// Property checker for dft_cmd_unit, attached by bind. Observes ports only.
module dft_cmd_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          cmd_busy,
    input logic          rsp_valid,
    input logic          msg_valid,
    input logic          msg_kind,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_kind,
    input logic [DW-1:0] out_data,
    input logic          run_valid
);
    // R2: an accepted read completes in the very next cycle.
    a_r2_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_busy && cmd_op == 2'd3) |=> rsp_valid);

    // R2: a completion cycle is still a busy cycle.
    a_r2_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> cmd_busy);

    // R4: a stalled head message is held unchanged.
    a_r4_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_kind)));

    // R7: a thread starts running only due to an assignment message.
    a_r7_start_by_assign: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_valid) |-> $past(msg_valid && msg_kind == 1'b0));

    // R10: a thread stops running only at the end of a command.
    a_r10_stop_by_delete: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_valid) |-> $past(cmd_busy));
endmodule

bind dft_cmd_unit dft_cmd_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_busy  (cmd_busy),
    .rsp_valid (rsp_valid),
    .msg_valid (msg_valid),
    .msg_kind  (msg_kind),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_data  (out_data),
    .run_valid (run_valid)
);

// File: tb/dft_cmd_unit_test.sv
// Bench: behavioural cycle model (queue, counters) compared every clock,
// plus directed checks on the stated corner cases.
module dft_cmd_unit_test;
    localparam int AW = 32, DW = 32, FD = 16, QD = 4, OFFW = 4;
    localparam int MSGW = 1 + AW + OFFW + DW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0; logic [1:0] cmd_op = 2'd1;
    logic [AW-1:0] cmd_fp = '0; logic [OFFW-1:0] cmd_off = '0; logic [DW-1:0] cmd_data = '0;
    logic cmd_busy, rsp_valid; logic [DW-1:0] rsp_data;
    logic msg_valid = 0, msg_kind = 0; logic [AW-1:0] msg_ip = '0, msg_fp = '0;
    logic [OFFW-1:0] msg_off = '0; logic [DW-1:0] msg_data = '0;
    logic out_valid, out_ready = 1'b1, out_kind;
    logic [AW-1:0] out_fp; logic [OFFW-1:0] out_off; logic [DW-1:0] out_data;
    logic run_valid; logic [AW-1:0] run_ip, run_fp;

    always #5 clk = ~clk;

    dft_cmd_unit uut (.*);

    int n_chk = 0, n_fail = 0;
    bit rand_on = 0, finished = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int            m_cnt = 0;
    logic [1:0]    m_op = 0;
    logic [AW-1:0] m_fp = 0; logic [OFFW-1:0] m_off = 0; logic [DW-1:0] m_data = 0;
    bit            m_run_v = 0, m_pend_v = 0;
    logic [AW-1:0] m_ip = 0, m_rfp = 0, m_pip = 0, m_pfp = 0;
    logic [DW-1:0] m_frame [FD];
    logic [MSGW-1:0] q[$];

    function automatic int lat(input logic [1:0] op);
        return (op == 0) ? 3 : (op == 3) ? 1 : 2;
    endfunction

    function automatic bit m_busy();
        return (m_cnt > 0) || ((cmd_op == 0 || cmd_op == 2) && q.size() == QD);
    endfunction

    // Advance the model on each rising edge, using pre-edge inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_run_v = 0; m_pend_v = 0; q.delete();
            for (int i = 0; i < FD; i++) m_frame[i] = '0;
        end else begin
            bit busy_pre, done, acc;
            busy_pre = m_busy();
            done = (m_cnt == 1);
            acc = cmd_valid && !busy_pre;
            if (q.size() > 0 && out_ready) void'(q.pop_front());
            if (done && (m_op == 0 || m_op == 2)) q.push_back({(m_op == 0), m_fp, m_off, m_data});
            if (done && m_op == 1) begin
                if (m_pend_v) begin m_ip = m_pip; m_rfp = m_pfp; m_pend_v = 0; end
                else m_run_v = 0;
            end
            if (msg_valid) begin
                if (msg_kind) m_frame[msg_off] = msg_data;
                else if (!m_run_v) begin m_run_v = 1; m_ip = msg_ip; m_rfp = msg_fp; end
                else if (!m_pend_v) begin m_pend_v = 1; m_pip = msg_ip; m_pfp = msg_fp; end
            end
            if (m_cnt > 0) m_cnt--;
            if (acc) begin
                m_cnt = lat(cmd_op); m_op = cmd_op;
                m_fp = cmd_fp; m_off = cmd_off; m_data = cmd_data;
            end
        end
    end

    // Compare the design against the model mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit rd_done;
            rd_done = (m_cnt == 1) && (m_op == 3);
            chk("R2 cmd_busy", cmd_busy, m_busy());
            chk("R2 rsp_valid", rsp_valid, rd_done);
            if (rd_done) chk("R3 rsp_data", rsp_data, m_frame[m_off]);
            chk("R4 out_valid", out_valid, q.size() > 0);
            if (q.size() > 0) chk("R4 out head", {out_kind, out_fp, out_off, out_data}, q[0]);
            chk("R7 run_valid", run_valid, m_run_v);
            if (m_run_v) chk("R8 run_ip/fp", {run_ip, run_fp}, {m_ip, m_rfp});
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] fp,
                         input logic [OFFW-1:0] off, input logic [DW-1:0] d);
        cmd_valid = 1; cmd_op = op; cmd_fp = fp; cmd_off = off; cmd_data = d;
        @(negedge clk);
        while (cmd_busy) @(negedge clk);
        @(posedge clk); #2;
        cmd_valid = 0; cmd_op = 2'd1;
    endtask

    task automatic send(input logic kind, input logic [AW-1:0] ip, input logic [AW-1:0] fp,
                        input logic [OFFW-1:0] off, input logic [DW-1:0] d);
        msg_valid = 1; msg_kind = kind; msg_ip = ip; msg_fp = fp; msg_off = off; msg_data = d;
        @(posedge clk); #2;
        msg_valid = 0;
    endtask

    // Random out_ready and incoming messages during the random phase.
    always @(posedge clk) begin
        if (rand_on) begin
            #2;
            out_ready = ($urandom % 3) != 0;
            msg_valid = ($urandom % 4) == 0;
            msg_kind  = $urandom % 2;
            msg_ip    = $urandom; msg_fp = $urandom;
            msg_off   = $urandom; msg_data = $urandom;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk("R1 run_valid", run_valid, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 cmd_busy", cmd_busy, 0);
        @(posedge clk); #2;

        for (int i = 0; i < FD; i++) send(1'b1, 0, 0, OFFW'(i), 32'hA000_0000 + i * 3);
        issue(2'd3, 0, 4'd5, 0);
        @(negedge clk);
        chk("R6 fill then read", rsp_data, 32'hA000_000F);
        chk("R3 read valid", rsp_valid, 1);
        chk("R3 no message from read", out_valid, 0);
        @(posedge clk); #2;

        send(1'b0, 32'h100, 32'h200, 0, 0);
        @(negedge clk);
        chk("R7 assign when idle", {run_valid, run_ip, run_fp}, {1'b1, 32'h100, 32'h200});
        @(posedge clk); #2;
        send(1'b0, 32'h300, 32'h400, 0, 0);
        send(1'b0, 32'h500, 32'h600, 0, 0);
        @(negedge clk);
        chk("R8 running kept", run_ip, 32'h100);
        @(posedge clk); #2;
        issue(2'd1, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R8 pending promoted", {run_valid, run_ip, run_fp}, {1'b1, 32'h300, 32'h400});
        @(posedge clk); #2;
        issue(2'd1, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R9 third assign ignored / R10 cleared", run_valid, 0);
        @(posedge clk); #2;

        out_ready = 0;
        for (int i = 0; i < QD; i++) issue(2'd2, 32'h40 + i, OFFW'(i), 32'hD0 + i);
        repeat (3) @(posedge clk); #2;
        cmd_op = 2'd2;
        @(negedge clk);
        chk("R5 write stalled when full", cmd_busy, 1);
        chk("R4 head is first write", {out_kind, out_data}, {1'b0, 32'hD0});
        @(posedge clk); #2;
        cmd_op = 2'd3;
        @(negedge clk);
        chk("R5 read allowed when full", cmd_busy, 0);
        @(posedge clk); #2;
        out_ready = 1;
        issue(2'd0, 32'h77, 4'd2, 32'h1234);
        repeat (3) @(negedge clk);
        chk("R2 create busy 3rd cycle", cmd_busy, 1);
        @(negedge clk);
        chk("R2 create done", cmd_busy, 0);
        @(posedge clk); #2;

        rand_on = 1;
        for (int k = 0; k < 400; k++)
            issue(2'($urandom), $urandom, OFFW'($urandom), $urandom);
        rand_on = 0;
        @(posedge clk); #2;
        msg_valid = 0; out_ready = 1;
        repeat (10) @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        finished = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule